// File: doc/BRIEF.md
# Frame-Sync Serial Slave with Output Hold

This block is the receive and transmit end of a synchronous serial link that marks each byte with a short frame-sync pulse instead of a held chip select. It runs entirely on the system clock. The serial clock, the frame-sync line and the incoming data line each pass through a two-flop synchronizer. Edges of the serial clock and of the frame-sync are then found in the system clock domain. A byte placed in the transmit buffer goes out most significant bit first. The incoming byte is assembled the same way and offered with a one-cycle valid strobe.

The frame-sync is active high. Its falling edge opens a frame. Rising serial clock edges advance the outgoing bit, and falling edges sample the incoming bit. The far end samples the last outgoing bit half a bit time after it changes. For this reason the slave keeps driving that bit after the frame ends, for a hold window set by a 3-bit prescaler value. The window is half a bit period plus a fixed extra number of clock cycles. After the window the output enable drops and the pin is free. A frame-sync edge that arrives while a byte is only partly received is reported through a sticky error flag, and that byte is dropped.

Each serial clock phase must last at least four system clock cycles. The prescaler value must stay stable from the start of a frame until the hold window has ended.

Top module: `spi_ti_slave`

## Requirements
- R1: After reset, `miso_oe_o`, `rx_valid_o` and `ferr_o` are all 0.
- R2: A falling edge of `nss_i` while no byte is partway received starts a frame. The frame loads the transmit buffer, drives its bit 7 on `miso_o` and sets `miso_oe_o` to 1.
- R3: Within a frame, each rising `sck_i` edge that follows a sample moves `miso_o` to the next lower bit. The byte goes out in the order bit 7 down to bit 0, and `miso_o` does not change at any other time while it is driven.
- R4: `mosi_i` is sampled on each falling `sck_i` edge of a frame, the first sample becoming bit 7. After the 8th sample, `rx_data_o` holds the byte and `rx_valid_o` is 1 for exactly one cycle.
- R5: `miso_oe_o` stays 1, with `miso_o` still showing bit 0, for exactly Td = 2^psc + 5 clock cycles, the cycle in which `rx_valid_o` is 1 included. It is then 0. With psc = 2 this gives 9 cycles.
- R6: An edge of either direction on `nss_i` after 1 to 7 bits of a byte have been sampled sets `ferr_o`. It also drops `miso_oe_o` and abandons the byte, so no `rx_valid_o` pulse is given for it.
- R7: `ferr_o` stays 1 through later frames until a one-cycle pulse on `ferr_clr_i` returns it to 0.
- R8: Frame-sync edges between frames or during the hold window do not set `ferr_o`. A rising edge during the hold window does not shorten that window.
- R9: A pulse on `tx_load_i` stores `tx_data_i` for the next frame start. A load made during a frame does not change the byte already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| nss_i | input | 1 | Frame-sync pulse, active high |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o`; 0 means the pin is released |
| tx_data_i | input | 8 | Byte to send |
| tx_load_i | input | 1 | Stores `tx_data_i` into the transmit buffer |
| rx_data_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new `rx_data_o` |
| psc_i | input | 3 | Prescaler value that sets the hold window |
| ferr_o | output | 1 | Sticky frame-error flag |
| ferr_clr_i | input | 1 | Clears `ferr_o` |

## Verification
Directed frames cover the all-ones, all-zeros and alternating bytes at the smallest, the largest and the middle prescaler values. These separate a wrong hold length from a wrong bit order, because the hold count depends only on psc and the bit pattern depends only on the data. Frames with random data and random prescaler settings are mixed in to catch shift or count errors that depend on a particular pattern. Aborts after 3 and after 7 sampled bits, a frame-sync rise inside the hold window, and a buffer load in the middle of a frame tell apart real mid-byte errors, harmless sync edges, and a buffer that is read at the wrong time.

// File: rtl/spi_ti_pkg.sv
package spi_ti_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2
  } frame_state_t;

  // Half a bit period is 2^psc clocks; the hold window adds a fixed extra.
  function automatic int unsigned hold_cycles(input int unsigned psc,
                                              input int unsigned extra);
    return (32'd1 << psc) + extra;
  endfunction

endpackage

// File: rtl/spi_ti_edge.sv
module spi_ti_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/spi_ti_shifter.sv
module spi_ti_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_next_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      tx_sr <= tx_byte_i;
      cnt_q <= '0;
    end else begin
      if (shift_i)
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (sample_i) begin
        rx_sr <= rx_next_o;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rx_next_o = {rx_sr[DATA_W-2:0], sdi_i};
  assign sdo_o     = tx_sr[DATA_W-1];
  assign count_o   = cnt_q;
endmodule

// File: rtl/spi_ti_hold_timer.sv
module spi_ti_hold_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             cancel_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cancel_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= len_i - 1'b1;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign expire_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_ti_slave.sv
module spi_ti_slave #(
  parameter int DATA_W      = 8,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_EXTRA  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              nss_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [PSC_W-1:0]  psc_i,
  output logic              ferr_o,
  input  logic              ferr_clr_i
);
  import spi_ti_pkg::*;

  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int HOLD_W  = (1 << PSC_W) + 1;
  localparam int N_PINS  = 3;
  localparam int IX_SCK  = 0;
  localparam int IX_NSS  = 1;
  localparam int IX_MOSI = 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  // Synchronizers and edge detection, one per input pin
  logic [N_PINS-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {mosi_i, nss_i, sck_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    spi_ti_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_raw[g]),
      .level_o (pin_lvl[g]),
      .rise_o  (pin_rise[g]),
      .fall_o  (pin_fall[g])
    );
  end

  // Named events for the checker
  logic sck_rise, sck_fall, nss_rise, nss_fall, mosi_lvl;
  logic frame_start, mid_toggle, sample_bit, shift_bit, byte_done;
  logic hold_release, tmr_expire;
  logic unused_pins;

  assign sck_rise    = pin_rise[IX_SCK];
  assign sck_fall    = pin_fall[IX_SCK];
  assign nss_rise    = pin_rise[IX_NSS];
  assign nss_fall    = pin_fall[IX_NSS];
  assign mosi_lvl    = pin_lvl[IX_MOSI];
  assign unused_pins = ^{pin_lvl[IX_SCK], pin_lvl[IX_NSS],
                         pin_rise[IX_MOSI], pin_fall[IX_MOSI]};

  frame_state_t      state_q;
  logic [DATA_W-1:0] tx_buf_q;
  logic [DATA_W-1:0] rx_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic [HOLD_W-1:0] td_len;
  logic              in_byte;

  assign in_byte      = (state_q == ST_ACTIVE) && (bit_cnt != '0);
  assign mid_toggle   = in_byte && (nss_rise || nss_fall);
  assign frame_start  = nss_fall && !in_byte;
  assign sample_bit   = (state_q == ST_ACTIVE) && sck_fall && !mid_toggle && !frame_start;
  assign shift_bit    = in_byte && sck_rise && !mid_toggle;
  assign byte_done    = sample_bit && (bit_cnt == LAST_BIT);
  assign hold_release = (state_q == ST_HOLD) && tmr_expire && !nss_fall;
  assign td_len       = HOLD_W'(hold_cycles(int'(psc_i), HOLD_EXTRA));

  spi_ti_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (frame_start),
    .tx_byte_i (tx_buf_q),
    .shift_i   (shift_bit),
    .sample_i  (sample_bit),
    .sdi_i     (mosi_lvl),
    .sdo_o     (miso_o),
    .rx_next_o (rx_next),
    .count_o   (bit_cnt)
  );

  spi_ti_hold_timer #(.CNT_W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (byte_done),
    .len_i    (td_len),
    .cancel_i (frame_start),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tx_buf_q   <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      ferr_o     <= 1'b0;
    end else begin
      if (tx_load_i) tx_buf_q <= tx_data_i;
      rx_valid_o <= byte_done;
      if (byte_done) rx_data_o <= rx_next;
      if (mid_toggle)      ferr_o <= 1'b1;
      else if (ferr_clr_i) ferr_o <= 1'b0;
      unique case (state_q)
        ST_IDLE:   if (frame_start) state_q <= ST_ACTIVE;
        ST_ACTIVE: begin
          if (mid_toggle)     state_q <= ST_IDLE;
          else if (byte_done) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (frame_start)       state_q <= ST_ACTIVE;
          else if (hold_release) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign miso_oe_o = (state_q != ST_IDLE);
endmodule

// File: rtl/spi_ti_slave_chk.sv
module spi_ti_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic miso_o,
  input logic miso_oe_o,
  input logic rx_valid_o,
  input logic ferr_o,
  input logic ferr_clr_i,
  input logic frame_start,
  input logic mid_toggle,
  input logic hold_release,
  input logic sck_rise
);
  AST_FRAME_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> miso_oe_o); // R2
  AST_MISO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o && !sck_rise && !frame_start) |=> $stable(miso_o)); // R3
  AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R4
  AST_RXV_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> miso_oe_o); // R5
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_release |=> !miso_oe_o); // R5
  AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mid_toggle |=> (ferr_o && !miso_oe_o)); // R6
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_o && !ferr_clr_i) |=> ferr_o); // R7
  AST_FERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_clr_i && !mid_toggle) |=> !ferr_o); // R7
endmodule

bind spi_ti_slave spi_ti_slave_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .miso_o       (miso_o),
  .miso_oe_o    (miso_oe_o),
  .rx_valid_o   (rx_valid_o),
  .ferr_o       (ferr_o),
  .ferr_clr_i   (ferr_clr_i),
  .frame_start  (frame_start),
  .mid_toggle   (mid_toggle),
  .hold_release (hold_release),
  .sck_rise     (sck_rise)
);

// File: tb/spi_ti_slave_tb_top.sv
module spi_ti_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, nss = 1'b0, mosi = 1'b0;
  logic       miso, miso_oe, rx_valid, ferr, ferr_clr = 1'b0, tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic [2:0] psc = 3'd0;

  int n_chk = 0, n_fail = 0;
  int rxn = 0, hlen = 0;
  bit hrun = 0, finished = 0;
  logic [7:0] rx_last = 8'h00;

  always #2 clk = ~clk;

  spi_ti_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .nss_i(nss), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_data_i(tx_data), .tx_load_i(tx_load),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .psc_i(psc),
    .ferr_o(ferr), .ferr_clr_i(ferr_clr)
  );

  function automatic int td_of(input int p);
    return (1 << p) + 5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Receive strobe and hold-window monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rxn++;
        rx_last = rx_data;
        hrun = 1;
        hlen = miso_oe ? 1 : 0;
      end else if (hrun) begin
        if (miso_oe) hlen++;
        else hrun = 0;
      end
    end
  end

  task automatic load_tx(input logic [7:0] b);
    tx_data = b; tx_load = 1'b1; wait_clk(1); tx_load = 1'b0; wait_clk(1);
  endtask

  task automatic run_frame(input logic [7:0] exp_tx, input logic [7:0] mo,
                           input int abort_at, input bit hold_pulse,
                           input bit mid_load, input logic [7:0] new_tx);
    int h;
    h = (1 << psc) + 8;
    nss = 1'b1; sck = 1'b1; wait_clk(h); sck = 1'b0; wait_clk(h);
    nss = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b1; mosi = mo[i];
      wait_clk(h);
      chk(miso_oe && miso == exp_tx[i], (i == 7) ? "R2 first bit" : "R3 bit order",
          {miso_oe, miso}, {1'b1, exp_tx[i]});
      if (mid_load && i == 4) begin
        tx_data = new_tx; tx_load = 1'b1; wait_clk(1); tx_load = 1'b0;
      end
      sck = 1'b0;
      if (i == 0) begin
        wait_clk(5);
        chk(miso_oe && miso == exp_tx[0], "R5 lsb held", {miso_oe, miso}, {1'b1, exp_tx[0]});
        if (hold_pulse) nss = 1'b1;
        wait_clk(h - 5);
      end else begin
        wait_clk(h);
      end
      if (abort_at == 8 - i) begin
        nss = 1'b1;
        wait_clk(6);
        chk(ferr == 1'b1, "R6 ferr set", ferr, 1);
        chk(miso_oe == 1'b0, "R6 released", miso_oe, 0);
        return;
      end
    end
  endtask

  task automatic post_checks(input logic [7:0] mo, input int rx_before, input bit exp_ferr);
    wait_clk(td_of(psc) + 12);
    chk(rxn == rx_before + 1, "R4 one strobe", rxn - rx_before, 1);
    chk(rx_last == mo, "R4 rx byte", rx_last, mo);
    chk(hlen == td_of(psc), "R5 hold length", hlen, td_of(psc));
    chk(miso_oe == 1'b0, "R5 released", miso_oe, 0);
    chk(ferr == exp_ferr, "R8 ferr untouched", ferr, exp_ferr);
  endtask

  task automatic full_frame(input logic [2:0] p, input logic [7:0] tx, input logic [7:0] mo);
    int rb;
    psc = p;
    load_tx(tx);
    rb = rxn;
    run_frame(tx, mo, 0, 0, 0, 8'h00);
    post_checks(mo, rb, 1'b0);
  endtask

  initial begin
    int rb;
    void'($urandom(32'h00C0FFEE));
    wait_clk(5);
    chk(miso_oe == 1'b0, "R1 oe", miso_oe, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(ferr == 1'b0, "R1 ferr", ferr, 0);
    rst_n = 1'b1;
    wait_clk(3);

    full_frame(3'd2, 8'hA5, 8'h3C);
    full_frame(3'd0, 8'h81, 8'h7E);
    full_frame(3'd7, 8'hFF, 8'h00);
    full_frame(3'd1, 8'h00, 8'hFF);

    // R8: frame-sync rise inside the hold window
    psc = 3'd3; load_tx(8'h96); rb = rxn;
    run_frame(8'h96, 8'h69, 0, 1, 0, 8'h00);
    post_checks(8'h69, rb, 1'b0);

    // R9: load during a frame affects only the next frame
    psc = 3'd2; load_tx(8'h5A); rb = rxn;
    run_frame(8'h5A, 8'h12, 0, 0, 1, 8'hC3);
    post_checks(8'h12, rb, 1'b0);
    rb = rxn;
    run_frame(8'hC3, 8'h34, 0, 0, 0, 8'h00);
    post_checks(8'h34, rb, 1'b0);
    chk(1'b1, "R9 covered by bit checks", 0, 0);

    // R6/R7: abort after 3 bits, flag sticks, then clears
    load_tx(8'h11); rb = rxn;
    run_frame(8'h11, 8'hAA, 3, 0, 0, 8'h00);
    wait_clk(40);
    chk(rxn == rb, "R6 byte dropped", rxn - rb, 0);
    chk(ferr == 1'b1, "R7 sticky", ferr, 1);
    rb = rxn;
    run_frame(8'h11, 8'h55, 0, 0, 0, 8'h00);
    post_checks(8'h55, rb, 1'b1);
    chk(ferr == 1'b1, "R7 sticky after frame", ferr, 1);
    ferr_clr = 1'b1; wait_clk(1); ferr_clr = 1'b0; wait_clk(2);
    chk(ferr == 1'b0, "R7 cleared", ferr, 0);

    // R6: abort after 7 bits (last mid-byte position)
    load_tx(8'hE7); rb = rxn;
    run_frame(8'hE7, 8'h0F, 7, 0, 0, 8'h00);
    wait_clk(40);
    chk(rxn == rb, "R6 byte dropped at bit 7", rxn - rb, 0);
    ferr_clr = 1'b1; wait_clk(1); ferr_clr = 1'b0; wait_clk(2);
    chk(ferr == 1'b0, "R7 cleared again", ferr, 0);

    // Random frames
    for (int k = 0; k < 12; k++) begin
      full_frame(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule